// File: doc/BRIEF.md
# Mode-Aware Status Register Write Controller

This block holds a 32-bit processor status word. It decides which bits a move-to-status write may change, based on the category of each bit and on the current privilege mode. A move-to-status request carries a data word and a four-bit byte mask. A separate exception-entry port can load every defined bit in one cycle, including the execution-state bits and the mode.

Every mode value that reaches the register is checked against the seven legal encodings. If an illegal code is written from a privileged mode, the register goes to System mode and does not store that code. The block drives the current status word, the 5-bit mode code and a privileged flag. The privileged flag is also the block's own input for deciding which bits a write may touch.

Top module: `psr_write_ctrl`

## Requirements
- R1: After reset the status word is 0x000001D3. This is Supervisor mode (10011) with A (bit 8), I (bit 7) and F (bit 6) set and every flag clear.
- R2: A move-to-status write changes the free bits in every mode, User included. The free bits are N=31, Z=30, C=29, V=28, Q=27, GE=[19:16] and E=9.
- R3: Execution-state bits [26:24], [15:10] and [5] are never changed by a move-to-status write, in any mode.
- R4: In User mode (10000), a move-to-status write leaves A, I, F and the mode field M=[4:0] unchanged.
- R5: In any privileged mode (any legal mode other than User), a move-to-status write changes A, I, F and M.
- R6: If a privileged move-to-status write enables byte 0 and carries a mode code outside {10000, 10001, 10010, 10011, 10111, 11011, 11111}, the mode field becomes 11111 (System).
- R7: Mask bit k enables byte k, which is status bits [8k+7:8k]. Bits in a byte whose mask bit is clear keep their value.
- R8: An exception-entry write loads every defined bit from its data word, in any mode. It wins over a move-to-status write in the same cycle. An illegal mode code in its data also becomes System.
- R9: Bits [23:20] read as zero whatever is written to them.
- R10: `modeCode` equals status bits [4:0]. `privileged` is 1 exactly when the mode is not User.
- R11: With no write request, the status word holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mtsValid | input | 1 | Move-to-status write request |
| mtsMask | input | 4 | Byte enables of the move-to-status write |
| mtsData | input | 32 | Move-to-status data word |
| excValid | input | 1 | Exception-entry write request |
| excData | input | 32 | Exception-entry status word |
| statusWord | output | 32 | Current status word |
| modeCode | output | 5 | Current mode field |
| privileged | output | 1 | High when the current mode is not User |

## Verification
An exception entry and a move-to-status write can arrive in the same cycle. They carry opposite data, and the move-to-status write has all four bytes enabled. The bench drives both requests on one clock edge, from User mode and from a privileged mode. It then compares the whole status word with the exception data after undefined bits are cleared and the mode is made legal. No bit written by the move-to-status request may survive.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int WordW  = 32;
  localparam int ByteW  = 8;
  localparam int ByteN  = WordW / ByteW;
  localparam int ModeW  = 5;

  typedef enum logic [ModeW-1:0] {
    MODE_USR = 5'b10000,
    MODE_FIQ = 5'b10001,
    MODE_IRQ = 5'b10010,
    MODE_SVC = 5'b10011,
    MODE_ABT = 5'b10111,
    MODE_UND = 5'b11011,
    MODE_SYS = 5'b11111
  } cpuMode_e;

  // bit categories
  localparam logic [WordW-1:0] FreeBits  = 32'hF80F_0200;
  localparam logic [WordW-1:0] ExecBits  = 32'h0700_FC20;
  localparam logic [WordW-1:0] PrivBits  = 32'h0000_01DF;
  localparam logic [WordW-1:0] DefBits   = FreeBits | ExecBits | PrivBits;
  localparam logic [WordW-1:0] ResetWord = 32'h0000_01C0 | {27'b0, MODE_SVC};

  typedef struct packed {
    logic             excLoad;
    logic             mtsLoad;
    logic [WordW-1:0] bitEnable;
  } psrStrobe_t;

  function automatic logic isLegalMode(input logic [ModeW-1:0] m);
    case (m)
      MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC,
      MODE_ABT, MODE_UND, MODE_SYS: isLegalMode = 1'b1;
      default:                      isLegalMode = 1'b0;
    endcase
  endfunction

  function automatic logic [WordW-1:0] fixMode(input logic [WordW-1:0] w);
    logic [WordW-1:0] r;
    r = w;
    if (!isLegalMode(w[ModeW-1:0])) r[ModeW-1:0] = MODE_SYS;
    return r;
  endfunction
endpackage

// File: rtl/psr_ctrl.sv
module psr_ctrl
  import psr_pkg::*;
(
  input  logic             mtsValid,
  input  logic [ByteN-1:0] mtsMask,
  input  logic             excValid,
  input  logic             privileged,
  output psrStrobe_t       strobe
);
  logic [WordW-1:0] byteEnable;
  logic [WordW-1:0] categoryEnable;

  for (genvar b = 0; b < ByteN; b++) begin : g_byte
    assign byteEnable[b*ByteW +: ByteW] = {ByteW{mtsMask[b]}};
  end

  always_comb begin
    categoryEnable = FreeBits;
    if (privileged) categoryEnable = categoryEnable | PrivBits;
  end

  always_comb begin
    strobe.excLoad   = excValid;
    strobe.mtsLoad   = mtsValid & ~excValid;
    strobe.bitEnable = byteEnable & categoryEnable;
  end
endmodule

// File: rtl/psr_datapath.sv
module psr_datapath
  import psr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  psrStrobe_t       strobe,
  input  logic [WordW-1:0] mtsData,
  input  logic [WordW-1:0] excData,
  output logic [WordW-1:0] statusWord,
  output logic [ModeW-1:0] modeCode,
  output logic             privileged
);
  logic [WordW-1:0] statusQ;
  logic [WordW-1:0] mtsMerged;
  logic [WordW-1:0] mtsNext;
  logic [WordW-1:0] excNext;
  logic [WordW-1:0] statusD;
  logic             modeTouched;

  always_comb begin
    mtsMerged   = (statusQ & ~strobe.bitEnable) | (mtsData & strobe.bitEnable);
    modeTouched = |strobe.bitEnable[ModeW-1:0];
    mtsNext     = modeTouched ? fixMode(mtsMerged) : mtsMerged;
    excNext     = fixMode(excData & DefBits);
    if (strobe.excLoad)      statusD = excNext;
    else if (strobe.mtsLoad) statusD = mtsNext;
    else                     statusD = statusQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) statusQ <= ResetWord;
    else       statusQ <= statusD;
  end

  assign statusWord = statusQ;
  assign modeCode   = statusQ[ModeW-1:0];
  assign privileged = (statusQ[ModeW-1:0] != MODE_USR);
endmodule

// File: rtl/psr_write_ctrl.sv
module psr_write_ctrl
  import psr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  mtsValid,
  input  logic [ByteN-1:0]      mtsMask,
  input  logic [WordW-1:0]      mtsData,
  input  logic                  excValid,
  input  logic [WordW-1:0]      excData,
  output logic [WordW-1:0]      statusWord,
  output logic [ModeW-1:0]      modeCode,
  output logic                  privileged
);
  psrStrobe_t strobe;

  psr_ctrl u_ctrl (
    .mtsValid  (mtsValid),
    .mtsMask   (mtsMask),
    .excValid  (excValid),
    .privileged(privileged),
    .strobe    (strobe)
  );

  psr_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .mtsData   (mtsData),
    .excData   (excData),
    .statusWord(statusWord),
    .modeCode  (modeCode),
    .privileged(privileged)
  );
endmodule

// File: rtl/psr_checker.sv
module psr_checker
  import psr_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             mtsValid,
  input logic [ByteN-1:0] mtsMask,
  input logic [WordW-1:0] mtsData,
  input logic             excValid,
  input logic [WordW-1:0] excData,
  input logic [WordW-1:0] statusWord,
  input logic [ModeW-1:0] modeCode,
  input logic             privileged
);
  p_reset_word_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> statusWord == ResetWord);

  p_exec_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (mtsValid && !excValid) |=> (statusWord & ExecBits) == ($past(statusWord) & ExecBits));

  p_user_priv_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (mtsValid && !excValid && !privileged) |=> (statusWord & PrivBits) == ($past(statusWord) & PrivBits));

  p_legal_mode_r6: assert property (@(posedge clk) disable iff (!rstN)
    isLegalMode(modeCode));

  p_exc_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    excValid |=> statusWord[WordW-1:ModeW] == ($past(excData[WordW-1:ModeW]) & DefBits[WordW-1:ModeW]));

  p_undef_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[23:20] == 4'b0);

  p_priv_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    privileged == (statusWord[ModeW-1:0] != MODE_USR));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!mtsValid && !excValid) |=> $stable(statusWord));
endmodule

bind psr_write_ctrl psr_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .mtsValid  (mtsValid),
  .mtsMask   (mtsMask),
  .mtsData   (mtsData),
  .excValid  (excValid),
  .excData   (excData),
  .statusWord(statusWord),
  .modeCode  (modeCode),
  .privileged(privileged)
);

// File: tb/psr_write_ctrl_test.sv
module psr_write_ctrl_test;
  localparam logic [31:0] FREE = 32'hF80F_0200;
  localparam logic [31:0] EXEC = 32'h0700_FC20;
  localparam logic [31:0] PRIV = 32'h0000_01DF;
  localparam logic [31:0] DEF  = 32'hFF0F_FFFF;
  localparam logic [4:0]  USR  = 5'b10000;
  localparam logic [4:0]  SVC  = 5'b10011;
  localparam logic [4:0]  SYS  = 5'b11111;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mtsValid = 1'b0;
  logic [3:0]  mtsMask = 4'h0;
  logic [31:0] mtsData = 32'h0;
  logic        excValid = 1'b0;
  logic [31:0] excData = 32'h0;
  logic [31:0] statusWord;
  logic [4:0]  modeCode;
  logic        privileged;

  int total = 0;
  int bad   = 0;
  logic [4:0] legalList [7] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                                5'b10111, 5'b11011, 5'b11111};

  always #2 clk = ~clk;

  psr_write_ctrl uut (
    .clk(clk), .rstN(rstN), .mtsValid(mtsValid), .mtsMask(mtsMask),
    .mtsData(mtsData), .excValid(excValid), .excData(excData),
    .statusWord(statusWord), .modeCode(modeCode), .privileged(privileged)
  );

  function automatic logic legal(input logic [4:0] m);
    foreach (legalList[i]) if (legalList[i] == m) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] expMts(input logic [31:0] cur, input logic [3:0] mask,
                                         input logic [31:0] data);
    logic [31:0] en;
    logic [31:0] nxt;
    en = {{8{mask[3]}}, {8{mask[2]}}, {8{mask[1]}}, {8{mask[0]}}} &
         (FREE | ((cur[4:0] != USR) ? PRIV : 32'h0));
    nxt = (cur & ~en) | (data & en);
    if ((en[4:0] != 5'b0) && !legal(nxt[4:0])) nxt[4:0] = SYS;
    return nxt;
  endfunction

  function automatic logic [31:0] expExc(input logic [31:0] data);
    logic [31:0] nxt;
    nxt = data & DEF;
    if (!legal(nxt[4:0])) nxt[4:0] = SYS;
    return nxt;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mtsWrite(input logic [3:0] mask, input logic [31:0] data);
    @(negedge clk);
    mtsValid = 1'b1; mtsMask = mask; mtsData = data;
    @(negedge clk);
    mtsValid = 1'b0; mtsMask = 4'h0;
  endtask

  task automatic excWrite(input logic [31:0] data);
    @(negedge clk);
    excValid = 1'b1; excData = data;
    @(negedge clk);
    excValid = 1'b0;
  endtask

  task automatic test_reset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset word", statusWord, 32'h0000_01D3);
    check("R10 reset mode", {27'b0, modeCode}, {27'b0, SVC});
    check("R10 reset privileged", {31'b0, privileged}, 32'h1);
  endtask

  task automatic test_categories();
    logic [31:0] cur;
    logic [31:0] exp;
    foreach (legalList[i]) begin
      excWrite({27'b0, legalList[i]});
      check("R8 exc mode load", statusWord, {27'b0, legalList[i]});
      check("R10 modeCode", {27'b0, modeCode}, {27'b0, legalList[i]});
      check("R10 privileged", {31'b0, privileged}, {31'b0, legalList[i] != USR});
      cur = statusWord;
      exp = expMts(cur, 4'hF, 32'hFFFF_FFFF);
      mtsWrite(4'hF, 32'hFFFF_FFFF);
      check("R2 free bits set", statusWord & FREE, exp & FREE);
      check("R3 exec bits clear kept", statusWord & EXEC, 32'h0);
      if (legalList[i] == USR) check("R4 user priv hold", statusWord & PRIV, cur & PRIV);
      else                     check("R5 priv bits set", statusWord & PRIV, PRIV);
      excWrite(EXEC | {27'b0, legalList[i]} | FREE);
      cur = statusWord;
      exp = expMts(cur, 4'hF, 32'h0000_0000);
      mtsWrite(4'hF, 32'h0000_0000);
      check("R2 free bits clear", statusWord & FREE, 32'h0);
      check("R3 exec bits set kept", statusWord & EXEC, EXEC);
      if (legalList[i] == USR) check("R4 user priv hold", statusWord & PRIV, cur & PRIV);
      else                     check("R5 R6 priv write", statusWord & PRIV, exp & PRIV);
      check("R9 undefined zero", statusWord & ~DEF, 32'h0);
    end
  endtask

  task automatic test_byte_mask();
    for (int b = 0; b < 4; b++) begin
      logic [31:0] cur;
      excWrite({27'b0, SVC});
      cur = statusWord;
      mtsWrite(4'(1 << b), 32'hFFFF_FFFF);
      check("R7 single byte enable", statusWord, expMts(cur, 4'(1 << b), 32'hFFFF_FFFF));
    end
    excWrite(32'hF80F_0200 | {27'b0, SVC});
    mtsWrite(4'h0, 32'h0);
    check("R7 empty mask keeps word", statusWord, 32'hF80F_0200 | {27'b0, SVC});
  endtask

  task automatic test_mode_sweep();
    for (int m = 0; m < 32; m++) begin
      excWrite({27'b0, SVC});
      mtsWrite(4'h1, {27'b0, 5'(m)});
      check("R6 privileged mode sweep", {27'b0, modeCode},
            {27'b0, legal(5'(m)) ? 5'(m) : SYS});
      excWrite({27'b0, USR});
      mtsWrite(4'h1, {27'b0, 5'(m)});
      check("R4 user mode sweep", {27'b0, modeCode}, {27'b0, USR});
    end
  endtask

  task automatic test_collision();
    logic [4:0] starts [2] = '{USR, SVC};
    foreach (starts[i]) begin
      excWrite({27'b0, starts[i]});
      @(negedge clk);
      mtsValid = 1'b1; mtsMask = 4'hF; mtsData = 32'hFFFF_FFFF;
      excValid = 1'b1; excData = 32'h0700_0040 | {27'b0, 5'b10001};
      @(negedge clk);
      mtsValid = 1'b0; excValid = 1'b0; mtsMask = 4'h0;
      check("R8 exception wins collision", statusWord, expExc(32'h0700_0041 | 32'h10));
    end
    excWrite(32'hFFFF_FFF4);
    check("R8 R9 illegal exc mode", statusWord, expExc(32'hFFFF_FFF4));
  endtask

  task automatic test_idle();
    logic [31:0] cur;
    excWrite(32'hA805_8493);
    cur = statusWord;
    mtsData = 32'hFFFF_FFFF; excData = 32'h0;
    repeat (3) @(negedge clk);
    check("R11 idle hold", statusWord, cur);
  endtask

  initial begin
    test_reset();
    test_categories();
    test_byte_mask();
    test_mode_sweep();
    test_collision();
    test_idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule